// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block is a fully digital model of the feedback divider chain of a frequency synthesizer. It contains a dual-modulus prescaler, a 7-bit swallow counter and an 11-bit main counter, all clocked by the divided signal (the VCO clock). Together they emit one pulse on `fp_pulse` for every P·N + A input cycles. The swallow counter holds the prescaler at modulus P+1 for the first A prescaler cycles of each output period. The prescaler then runs at modulus P for the remaining N−A cycles. This needs A < N.

A separate 14-bit reference divider, clocked by the reference clock, emits one pulse on `fr_pulse` every R reference cycles. The synthesized frequency is therefore f_vco = (P·N + A)·f_ref / R. The pin `sel_small` picks the modulus pair: 1 selects 64/65 and 0 selects 128/129.

Configuration inputs are sampled only on the edge that closes a period. A change made part-way through never shortens or stretches the period in progress. Permitted ranges are N in 16..2047, A in 0..127 with A < N, and R in 8..16383. Values outside these ranges are the user's responsibility.

Top module: `pswl_divider`

## Requirements
- R1: While `rst` is high on a clock edge, `fp_pulse` and `fr_pulse` are 0. The divider state is loaded from the configuration inputs. After reset is released, the first `fp_pulse` appears after exactly P·N + A input clock edges.
- R2: `sel_small`=1 selects the modulus pair 64/65 (P=64). `sel_small`=0 selects 128/129 (P=128).
- R3: With stable configuration and A < N, successive `fp_pulse` assertions are exactly P·N + A input clock cycles apart.
- R4: With A=0, every prescaler cycle uses modulus P, and the period is P·N.
- R5: Within each output period the prescaler uses modulus P+1 for the first A prescaler cycles and P for the remaining ones. The modulus control only changes at the end of a prescaler cycle, and `fp_pulse` is raised only at the end of a prescaler cycle.
- R6: `fp_pulse` is high for exactly one input clock cycle per output period.
- R7: Successive `fr_pulse` assertions are exactly R reference clock cycles apart. Each is one reference cycle wide.
- R8: New N, A and `sel_small` values take effect only from the edge that ends the current output period. A value presented before that edge governs the next period, and a value presented after it waits a further period.
- R9: A new R value takes effect only from the reference edge that ends the current `fr_pulse` period.
- R10: The largest swallow count (A=127, N=130) gives a period of 64·130+127 = 8447 cycles with P=64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Divided input clock (VCO side) |
| ref_clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| cfg_n | input | 11 | Main counter value N |
| cfg_a | input | 7 | Swallow counter value A |
| cfg_r | input | 14 | Reference divide ratio R |
| sel_small | input | 1 | 1: modulus 64/65, 0: modulus 128/129 |
| fp_pulse | output | 1 | One-cycle pulse every P·N+A input cycles |
| fr_pulse | output | 1 | One-cycle pulse every R reference cycles |

## Verification
The period-closing reload and a configuration update can land on the same input edge. The bench provokes this by counting cycles from a detected pulse and changing N just before the terminal edge, then again just after it. It judges the outcome by measuring the two following pulse intervals: the in-flight period must keep its old length, and the new value must apply from the first or the second following period respectively. The same on-the-boundary and mid-period changes are applied to R on the reference side. A=N−1 is also exercised, so that the modulus switch falls on the penultimate prescaler cycle.

// File: rtl/pswl_pkg.sv
`timescale 1ns/1ps
package pswl_pkg;
    localparam int N_W          = 11;
    localparam int A_W          = 7;
    localparam int R_W          = 14;
    localparam int P_SMALL_DEF  = 64;
    localparam int P_LARGE_DEF  = 128;

    // configuration as presented at the block inputs
    typedef struct packed {
        logic           sel_small;
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
    } fb_cfg_t;

    // live counter state of one output period
    typedef struct packed {
        logic [N_W-1:0] n_left;
        logic [A_W-1:0] a_left;
        logic           sel_small;
    } fb_state_t;

    // prescaler cycle length for a given pair selection and swallow state
    function automatic int modulus(logic sel_small, logic swallow,
                                   int p_small, int p_large);
        return (sel_small ? p_small : p_large) + (swallow ? 1 : 0);
    endfunction
endpackage

// File: rtl/pswl_prescaler.sv
`timescale 1ns/1ps
module pswl_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] len_next,
    output logic             tick,
    output logic [PRE_W-1:0] cnt_o
);
    logic [PRE_W-1:0] cnt;

    // tick marks the last input cycle of a prescaler cycle
    assign tick  = (cnt == '0);
    assign cnt_o = cnt;

    always_ff @(posedge clk) begin
        if (rst || tick)
            cnt <= len_next - PRE_W'(1);
        else
            cnt <= cnt - PRE_W'(1);
    end
endmodule

// File: rtl/pswl_swallow.sv
`timescale 1ns/1ps
module pswl_swallow
    import pswl_pkg::*;
#(
    parameter int P_SMALL = P_SMALL_DEF,
    parameter int P_LARGE = P_LARGE_DEF,
    parameter int PRE_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  fb_cfg_t          cfg_in,
    output logic [PRE_W-1:0] len_next,
    output logic             mc,
    output logic             fp
);
    fb_state_t st, st_nx;
    logic      terminal;

    always_comb begin
        terminal = tick && (st.n_left <= N_W'(1));
        st_nx    = st;
        if (rst || terminal) begin
            // period boundary: the only point where configuration is sampled
            st_nx.n_left    = cfg_in.n;
            st_nx.a_left    = cfg_in.a;
            st_nx.sel_small = cfg_in.sel_small;
        end else if (tick) begin
            st_nx.n_left = st.n_left - N_W'(1);
            if (st.a_left != '0)
                st_nx.a_left = st.a_left - A_W'(1);
        end
        // look ahead: the length of the prescaler cycle that starts after this edge
        len_next = PRE_W'(modulus(st_nx.sel_small, st_nx.a_left != '0,
                                  P_SMALL, P_LARGE));
        mc = (st.a_left != '0);
    end

    always_ff @(posedge clk) begin
        st <= st_nx;
        if (rst)
            fp <= 1'b0;
        else
            fp <= terminal;
    end
endmodule

// File: rtl/pswl_refdiv.sv
`timescale 1ns/1ps
module pswl_refdiv
    import pswl_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [R_W-1:0] r_in,
    output logic           fr
);
    logic [R_W-1:0] cnt;
    logic           expire;

    assign expire = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || expire)
            cnt <= r_in - R_W'(1);
        else
            cnt <= cnt - R_W'(1);
        if (rst)
            fr <= 1'b0;
        else
            fr <= expire;
    end
endmodule

// File: rtl/pswl_divider.sv
`timescale 1ns/1ps
module pswl_divider
    import pswl_pkg::*;
#(
    parameter int P_SMALL = P_SMALL_DEF,
    parameter int P_LARGE = P_LARGE_DEF
) (
    input  logic           vco_clk,
    input  logic           ref_clk,
    input  logic           rst,
    input  logic [N_W-1:0] cfg_n,
    input  logic [A_W-1:0] cfg_a,
    input  logic [R_W-1:0] cfg_r,
    input  logic           sel_small,
    output logic           fp_pulse,
    output logic           fr_pulse
);
    localparam int PRE_W = $clog2(P_LARGE + 2);

    fb_cfg_t          cfg;
    logic             pre_tick;
    logic             swl_mc;
    logic [PRE_W-1:0] len_next;
    logic [PRE_W-1:0] pre_cnt;

    assign cfg.sel_small = sel_small;
    assign cfg.n         = cfg_n;
    assign cfg.a         = cfg_a;

    pswl_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (vco_clk),
        .rst      (rst),
        .len_next (len_next),
        .tick     (pre_tick),
        .cnt_o    (pre_cnt)
    );

    pswl_swallow #(.P_SMALL(P_SMALL), .P_LARGE(P_LARGE), .PRE_W(PRE_W)) u_swl (
        .clk      (vco_clk),
        .rst      (rst),
        .tick     (pre_tick),
        .cfg_in   (cfg),
        .len_next (len_next),
        .mc       (swl_mc),
        .fp       (fp_pulse)
    );

    pswl_refdiv u_ref (
        .clk  (ref_clk),
        .rst  (rst),
        .r_in (cfg_r),
        .fr   (fr_pulse)
    );
endmodule

// File: rtl/pswl_checker.sv
`timescale 1ns/1ps
module pswl_checker #(
    parameter int P_LARGE = 128,
    parameter int PRE_W   = 8
) (
    input logic             vco_clk,
    input logic             ref_clk,
    input logic             rst,
    input logic             fp,
    input logic             fr,
    input logic             tick,
    input logic             mc,
    input logic [PRE_W-1:0] pre_cnt
);
    // R6: output pulse lasts one input cycle
    a_r6_fp_one_wide: assert property (@(posedge vco_clk) disable iff (rst)
        fp |=> !fp);

    // R5: output pulse only closes a prescaler cycle
    a_r5_fp_on_tick: assert property (@(posedge vco_clk) disable iff (rst)
        fp |-> $past(tick));

    // R5: swallow phase ends only at a prescaler cycle boundary
    a_r5_mc_fall_on_tick: assert property (@(posedge vco_clk) disable iff (rst)
        ($fell(mc) && $past(!rst)) |-> $past(tick));

    // R5: modulus control steady inside a prescaler cycle
    a_r5_mc_stable: assert property (@(posedge vco_clk) disable iff (rst)
        !tick |=> $stable(mc));

    // R2: prescaler count never exceeds the largest modulus
    a_r2_pre_bound: assert property (@(posedge vco_clk) disable iff (rst)
        pre_cnt <= PRE_W'(P_LARGE));

    // R7: reference pulse lasts one reference cycle
    a_r7_fr_one_wide: assert property (@(posedge ref_clk) disable iff (rst)
        fr |=> !fr);
endmodule

bind pswl_divider pswl_checker #(.P_LARGE(P_LARGE), .PRE_W(PRE_W)) u_chk (
    .vco_clk (vco_clk),
    .ref_clk (ref_clk),
    .rst     (rst),
    .fp      (fp_pulse),
    .fr      (fr_pulse),
    .tick    (pre_tick),
    .mc      (swl_mc),
    .pre_cnt (pre_cnt)
);

// File: tb/sim_pswl_divider.sv
`timescale 1ns/1ps
module sim_pswl_divider;
    logic        vco_clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic        rst     = 1'b1;
    logic [10:0] cfg_n   = 11'd16;
    logic [6:0]  cfg_a   = 7'd0;
    logic [13:0] cfg_r   = 14'd8;
    logic        sel_small = 1'b1;
    logic        fp_pulse, fr_pulse;

    int checks = 0;
    int fails  = 0;

    always #4 vco_clk = ~vco_clk;   // 125 MHz
    always #5 ref_clk = ~ref_clk;

    pswl_divider u0 (
        .vco_clk   (vco_clk),
        .ref_clk   (ref_clk),
        .rst       (rst),
        .cfg_n     (cfg_n),
        .cfg_a     (cfg_a),
        .cfg_r     (cfg_r),
        .sel_small (sel_small),
        .fp_pulse  (fp_pulse),
        .fr_pulse  (fr_pulse)
    );

    // sel_small, N, A, expected period = (sel_small ? 64 : 128) * N + A
    localparam int VEC [6][4] = '{
        '{1,  16,   0, 1024},   // R4 R2
        '{1,  16,  15, 1039},   // R5
        '{1,  20,   7, 1287},   // R3
        '{0,  16,   1, 2049},   // R2
        '{0,  17,  16, 2192},   // R5 A = N-1
        '{1, 130, 127, 8447}    // R10
    };
    localparam int RVEC [3] = '{8, 13, 100};

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // counts input negedges from now until fp_pulse is seen high
    task automatic wait_fp(output int n);
        n = 0;
        do begin
            @(negedge vco_clk);
            n++;
        end while (fp_pulse !== 1'b1);
    endtask

    task automatic wait_fr(output int n);
        n = 0;
        do begin
            @(negedge ref_clk);
            n++;
        end while (fr_pulse !== 1'b1);
    endtask

    initial begin
        #1_200_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        // R1: outputs low while reset is held
        repeat (6) @(negedge vco_clk);
        check("R1 fp in reset", int'(fp_pulse), 0);
        check("R1 fr in reset", int'(fr_pulse), 0);
        rst = 1'b0;
        wait_fp(n);
        check("R1 first fp latency", n, 1024);

        // main function: table walk, R3 period under several patterns
        for (int i = 0; i < 6; i++) begin
            wait_fp(n);
            sel_small = VEC[i][0][0];
            cfg_n     = 11'(VEC[i][1]);
            cfg_a     = 7'(VEC[i][2]);
            wait_fp(n);              // period still running on old values
            wait_fp(n);
            check($sformatf("R3 R6 vector %0d", i), n, VEC[i][3]);
        end

        // back to N=16, A=0, P=64
        wait_fp(n);
        sel_small = 1'b1; cfg_n = 11'd16; cfg_a = 7'd0;
        wait_fp(n);
        // R8: change just before the terminal edge applies to the next period
        repeat (1023) @(negedge vco_clk);
        cfg_n = 11'd17;
        wait_fp(n);
        check("R8 in-flight period kept", n, 1);
        wait_fp(n);
        check("R8 new N from next period", n, 1088);
        // R8: change just after the terminal edge waits a further period
        wait_fp(n);
        check("R8 steady N=17", n, 1088);
        cfg_n = 11'd16;
        wait_fp(n);
        check("R8 late change deferred", n, 1088);
        wait_fp(n);
        check("R8 late change applied", n, 1024);

        // R7: reference divider periods
        for (int i = 0; i < 3; i++) begin
            wait_fr(n);
            cfg_r = 14'(RVEC[i]);
            wait_fr(n);
            wait_fr(n);
            check($sformatf("R7 R=%0d", RVEC[i]), n, RVEC[i]);
        end
        // R9: mid-period change of R
        wait_fr(n);
        repeat (3) @(negedge ref_clk);
        cfg_r = 14'd20;
        wait_fr(n);
        check("R9 in-flight R kept", n, 97);
        wait_fr(n);
        check("R9 new R applied", n, 20);
        cfg_r = 14'd8;
        wait_fr(n);
        check("R9 boundary change deferred", n, 20);
        wait_fr(n);
        check("R9 R=8 minimum", n, 8);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule